// File: doc/BRIEF.md
# USB Root Hub Downstream Port Status Controller

This block keeps the state of one downstream port of a full/low-speed root hub and presents it through a single 32-bit host-controller register. Software reads the register to learn the port state. Many bit positions have two meanings: a write of 1 issues a command, and a read returns status. The block runs a timed port reset and a timed resume sequence, paced by a 1 ms tick input. It also latches five change events, which software clears by writing 1 to them.

The line-side inputs come from a simple line-state model:
- device present;
- device is low speed;
- overcurrent indicator;
- a hardware error pulse that disables the port.

The resume sequence has three phases: a resume signal that lasts `RESUME_MS` ticks, then a low-speed end-of-packet that lasts `EOP_CYCLES` clocks, then a resynchronisation wait of `RESYNC_MS` ticks. A command that drives the port is refused while no device is present. Instead of acting, the block flags a connect change so that the driver looks at the port again. A parameter marks the port as non-removable. In that case the connect change is raised once after reset and is not raised by later line events.

Top module: `usb_rh_port_ctl`

## Requirements
- R1: Read bits 31:21, 15:10 and 7:6 always read 0. After reset, with no device present, the whole register reads 0 when the port is removable.
- R2: Change bits 20 (reset done), 19 (overcurrent changed), 18 (resume done), 17 (enable lost) and 16 (connect changed) each clear when software writes 1 to that bit position, and writing 0 leaves them unchanged. If a hardware set and a software clear of the same change bit arrive in the same cycle, the bit reads 1.
- R3: Read bit 0 shows device presence, one cycle after the line input. When the port is removable, every connect or disconnect sets bit 16.
- R4: Writing 1 to bit 4 (start reset), bit 1 (enable) or bit 2 (suspend) while read bit 0 is 0 changes no port state and sets bit 16.
- R5: Writing 1 to bit 4 while connected starts a reset, and read bit 4 shows 1 while the reset runs. On the `RESET_MS`-th tick after the write, bit 4 returns to 0, port enable (read bit 1) becomes 1, bit 20 sets, bit 18 is cleared and suspend (read bit 2) is cleared.
- R6: Writing 1 to bit 2 while the port is enabled sets suspend (read bit 2). Writing 1 to bit 3 while suspended starts a resume, and read bit 5 shows 1 while the resume runs. Suspend stays 1 until the full sequence ends (`RESUME_MS` ticks, then `EOP_CYCLES` clocks, then `RESYNC_MS` ticks). At that point suspend clears and bit 18 sets.
- R7: A pulse on `line_error` while the port is enabled clears enable and sets bit 17. Software writes to bit 0 (disable) or bit 1 (enable) change enable without ever setting bit 17.
- R8: A disconnect clears enable and suspend and aborts any running reset or resume. It does not set bit 17, and it sets no later bit 18 or bit 20.
- R9: Read bit 3 shows the overcurrent input one cycle late. When `PER_PORT_OC` is 1, every change of that input sets bit 19.
- R10: Read bit 9 shows a low-speed device while connected and reads 0 while disconnected. Writing 1 to bit 8 sets port power, writing 1 to bit 9 clears it, and read bit 8 shows port power.
- R11: With `NON_REMOVABLE` set to 1, bit 16 reads 1 in the first cycle after reset. Later connect and disconnect events do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-clock pulse every millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; a 1 in a position issues its command |
| rd_data | output | 32 | Port status and change bits |
| line_connect | input | 1 | Device present on the port |
| line_lowspeed | input | 1 | Attached device is low speed |
| line_overcurrent | input | 1 | Per-port overcurrent indicator |
| line_error | input | 1 | Hardware event that disables the port |

## Verification
A behavioural model in the bench is compared against the register on every clock. The stimulus includes:
- port commands issued while disconnected, which separate refusing a command from carrying it out;
- full reset and resume runs, sampled one tick before and after their ends, which expose off-by-one timer faults;
- a disconnect in the middle of a resume, which tells an abort apart from a late completion;
- `line_error` pulses mixed with software enable and disable writes, which tell hardware-caused enable changes from software-caused ones;
- an overcurrent edge that lands in the same cycle as a write-1 clear, which shows which of the two wins.

A second instance, marked non-removable, receives the same inputs. It shows that connect changes are reported once after reset and not on later line events.

// File: rtl/usb_rh_pkg.sv
package usb_rh_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RESET,
        SEQ_RESUME,
        SEQ_EOP,
        SEQ_RESYNC
    } seq_phase_e;

    // change bits, counted from the lowest change position upward
    localparam int CHG_N    = 5;
    localparam int CHG_BASE = 16;
    localparam int CH_CONN  = 0;
    localparam int CH_EN    = 1;
    localparam int CH_SUSP  = 2;
    localparam int CH_OC    = 3;
    localparam int CH_RST   = 4;

    // command / status positions
    localparam int P_CONN_DIS = 0;  // read: connected   write: disable
    localparam int P_EN       = 1;  // read: enabled     write: enable
    localparam int P_SUSP     = 2;  // read: suspended   write: suspend
    localparam int P_OC_RES   = 3;  // read: overcurrent write: resume
    localparam int P_RST      = 4;  // read: resetting   write: start reset
    localparam int P_RSM_ACT  = 5;  // read: resuming
    localparam int P_PWR      = 8;  // read: power       write: power on
    localparam int P_LS_POFF  = 9;  // read: low speed   write: power off

endpackage

// File: rtl/usb_rh_port_seq.sv
module usb_rh_port_seq
    import usb_rh_pkg::*;
#(
    parameter int RESET_MS   = 10,
    parameter int RESUME_MS  = 20,
    parameter int RESYNC_MS  = 3,
    parameter int EOP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_reset,
    input  logic start_resume,
    input  logic abort,
    output logic reset_active,
    output logic resume_active,
    output logic reset_done,
    output logic resume_done
);
    localparam int MAX_AB = (RESET_MS > RESUME_MS) ? RESET_MS : RESUME_MS;
    localparam int MAX_CD = (RESYNC_MS > EOP_CYCLES) ? RESYNC_MS : EOP_CYCLES;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RESET_MS - 1);
    localparam logic [CW-1:0] RSM_LAST  = CW'(RESUME_MS - 1);
    localparam logic [CW-1:0] EOP_LAST  = CW'(EOP_CYCLES - 1);
    localparam logic [CW-1:0] SYNC_LAST = CW'(RESYNC_MS - 1);

    typedef struct packed {
        seq_phase_e      phase;
        logic [CW-1:0]   cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        reset_done    = 1'b0;
        resume_done   = 1'b0;
        reset_active  = (st_q.phase == SEQ_RESET);
        resume_active = (st_q.phase == SEQ_RESUME) || (st_q.phase == SEQ_EOP)
                     || (st_q.phase == SEQ_RESYNC);
        if (abort) begin
            st_d.phase = SEQ_IDLE;
            st_d.cnt   = '0;
        end else if (start_reset) begin
            st_d.phase = SEQ_RESET;
            st_d.cnt   = '0;
        end else if (start_resume) begin
            st_d.phase = SEQ_RESUME;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.phase)
                SEQ_RESET: if (tick) begin
                    if (st_q.cnt == RST_LAST) begin
                        reset_done = 1'b1;
                        st_d.phase = SEQ_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                SEQ_RESUME: if (tick) begin
                    if (st_q.cnt == RSM_LAST) begin
                        st_d.phase = SEQ_EOP;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                SEQ_EOP: begin
                    if (st_q.cnt == EOP_LAST) begin
                        st_d.phase = SEQ_RESYNC;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                SEQ_RESYNC: if (tick) begin
                    if (st_q.cnt == SYNC_LAST) begin
                        resume_done = 1'b1;
                        st_d.phase  = SEQ_IDLE;
                        st_d.cnt    = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= SEQ_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/usb_rh_chg_bits.sv
module usb_rh_chg_bits #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] kill_i,
    output logic [N-1:0] chg_o
);
    logic [N-1:0] chg_d, chg_q;

    // a hardware set outranks a same-cycle software clear;
    // kill models a bit cleared by another hardware event
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            chg_d[i] = set_i[i] | (chg_q[i] & ~clr_i[i] & ~kill_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= chg_d;
    end

    assign chg_o = chg_q;

endmodule

// File: rtl/usb_rh_port_ctl.sv
module usb_rh_port_ctl
    import usb_rh_pkg::*;
#(
    parameter int RESET_MS      = 10,
    parameter int RESUME_MS     = 20,
    parameter int RESYNC_MS     = 3,
    parameter int EOP_CYCLES    = 4,
    parameter bit NON_REMOVABLE = 1'b0,
    parameter bit PER_PORT_OC   = 1'b1,
    parameter int DW            = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1ms,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          line_connect,
    input  logic          line_lowspeed,
    input  logic          line_overcurrent,
    input  logic          line_error
);
    typedef struct packed {
        logic conn;
        logic ls;
        logic oc;
        logic en;
        logic susp;
        logic pwr;
        logic first;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [DW-1:0]    w;
    logic             disc, bad_cmd;
    logic             start_reset, start_resume;
    logic             reset_active, resume_active, reset_done, resume_done;
    logic [CHG_N-1:0] chg_set, chg_clr, chg_kill, chg_q;
    logic             unused_wr;

    assign w         = wr_en ? wr_data : '0;
    assign unused_wr = ^{w[DW-1:CHG_BASE+CHG_N], w[CHG_BASE-1:P_LS_POFF+1], w[P_PWR-1:P_RST+1]};

    always_comb begin
        st_d         = st_q;
        disc         = st_q.conn & ~line_connect;
        bad_cmd      = ~st_q.conn & (w[P_RST] | w[P_EN] | w[P_SUSP]);
        start_reset  = st_q.conn & w[P_RST] & ~reset_active & ~disc;
        start_resume = st_q.conn & w[P_OC_RES] & st_q.susp & ~resume_active
                     & ~reset_active & ~w[P_RST] & ~disc;

        chg_set  = '0;
        chg_kill = '0;
        chg_clr  = w[CHG_BASE +: CHG_N];

        st_d.first = 1'b0;
        st_d.conn  = line_connect;
        st_d.ls    = line_lowspeed;
        st_d.oc    = line_overcurrent;

        // port enable: disconnect, then reset end, then hardware fault, then software
        if (disc)
            st_d.en = 1'b0;
        else if (reset_done)
            st_d.en = 1'b1;
        else if (line_error && st_q.en) begin
            st_d.en            = 1'b0;
            chg_set[CH_EN]     = 1'b1;
        end else if (w[P_CONN_DIS])
            st_d.en = 1'b0;
        else if (st_q.conn && w[P_EN])
            st_d.en = 1'b1;

        // suspend
        if (disc || reset_done || resume_done)
            st_d.susp = 1'b0;
        else if (st_q.conn && w[P_SUSP] && st_q.en && !reset_active && !start_reset)
            st_d.susp = 1'b1;

        // power
        if (w[P_LS_POFF])
            st_d.pwr = 1'b0;
        else if (w[P_PWR])
            st_d.pwr = 1'b1;

        // change events
        if (NON_REMOVABLE)
            chg_set[CH_CONN] = st_q.first | bad_cmd;
        else
            chg_set[CH_CONN] = (line_connect != st_q.conn) | bad_cmd;
        chg_set[CH_SUSP]  = resume_done;
        chg_set[CH_RST]   = reset_done;
        chg_set[CH_OC]    = PER_PORT_OC && (line_overcurrent != st_q.oc);
        chg_kill[CH_SUSP] = reset_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    usb_rh_port_seq #(
        .RESET_MS  (RESET_MS),
        .RESUME_MS (RESUME_MS),
        .RESYNC_MS (RESYNC_MS),
        .EOP_CYCLES(EOP_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_1ms),
        .start_reset  (start_reset),
        .start_resume (start_resume),
        .abort        (disc),
        .reset_active (reset_active),
        .resume_active(resume_active),
        .reset_done   (reset_done),
        .resume_done  (resume_done)
    );

    usb_rh_chg_bits #(.N(CHG_N)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (chg_set),
        .clr_i (chg_clr),
        .kill_i(chg_kill),
        .chg_o (chg_q)
    );

    always_comb begin
        rd_data                     = '0;
        rd_data[P_CONN_DIS]         = st_q.conn;
        rd_data[P_EN]               = st_q.en;
        rd_data[P_SUSP]             = st_q.susp;
        rd_data[P_OC_RES]           = st_q.oc;
        rd_data[P_RST]              = reset_active;
        rd_data[P_RSM_ACT]          = resume_active;
        rd_data[P_PWR]              = st_q.pwr;
        rd_data[P_LS_POFF]          = st_q.ls & st_q.conn;
        rd_data[CHG_BASE +: CHG_N]  = chg_q;
    end

endmodule

// File: rtl/usb_rh_port_chk.sv
module usb_rh_port_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          line_error,
    input logic [DW-1:0] rd_data
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:21] == '0 && rd_data[15:10] == '0 && rd_data[7:6] == '0);

    // R4
    refused_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[0] && wr_en && wr_data[4]) |=> (rd_data[16] && !rd_data[4]));

    // R5
    reset_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[20]) |-> (rd_data[1] && !rd_data[18] && !rd_data[2]));

    // R6
    resume_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[18]) |-> (!rd_data[2] && $past(rd_data[2])));

    // R7
    hw_only_pesc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[17]) |-> $past(line_error));

    // R8
    disc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[0]) |-> (!rd_data[1] && !rd_data[2] && !$rose(rd_data[17])));

    // R10
    ls_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> !rd_data[9]);

endmodule

bind usb_rh_port_ctl usb_rh_port_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .line_error(line_error),
    .rd_data   (rd_data)
);

// File: tb/sim_usb_rh_port_ctl.sv
`timescale 1ns/1ps
module sim_usb_rh_port_ctl;
    localparam int RMS = 10, SMS = 20, YMS = 3, EOPC = 4, TPER = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        lc = 1'b0, lls = 1'b0, loc = 1'b0, lerr = 1'b0;
    logic [31:0] rd0, rd1;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_rh_port_ctl u0 (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd0), .line_connect(lc), .line_lowspeed(lls),
        .line_overcurrent(loc), .line_error(lerr));

    usb_rh_port_ctl #(.NON_REMOVABLE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd1), .line_connect(lc), .line_lowspeed(lls),
        .line_overcurrent(loc), .line_error(lerr));

    // behavioural reference of u0
    bit mc, mls, moc, men, msus, mpwr;
    bit mcsc, mpesc, mpssc, mocic, mprsc;
    int mph, mcnt;   // 0 idle, 1 reset, 2 resume signal, 3 eop, 4 resync

    always @(posedge clk) begin
        bit disc, rdone, sdone, go_rst, go_rsm, bad, hwoff;
        bit [31:0] w;
        if (!rst_n) begin
            {mc, mls, moc, men, msus, mpwr} = '0;
            {mcsc, mpesc, mpssc, mocic, mprsc} = '0;
            mph = 0; mcnt = 0;
        end else begin
            w      = wr_en ? wr_data : 32'd0;
            disc   = mc && !lc;
            rdone  = !disc && mph == 1 && tick && mcnt == RMS - 1;
            sdone  = !disc && mph == 4 && tick && mcnt == YMS - 1;
            go_rst = mc && w[4] && mph != 1 && !disc;
            go_rsm = mc && w[3] && msus && mph == 0 && !w[4] && !disc;
            bad    = !mc && (w[4] || w[1] || w[2]);
            hwoff  = !disc && !rdone && lerr && men;

            mcsc  = (lc != mc) || bad || (mcsc && !w[16]);
            mpesc = hwoff || (mpesc && !w[17]);
            mpssc = sdone || (mpssc && !w[18] && !rdone);
            mocic = (loc != moc) || (mocic && !w[19]);
            mprsc = rdone || (mprsc && !w[20]);

            if (disc || rdone || sdone) msus = 0;
            else if (mc && w[2] && men && mph != 1 && !go_rst) msus = 1;

            if (disc) men = 0;
            else if (rdone) men = 1;
            else if (hwoff) men = 0;
            else if (w[0]) men = 0;
            else if (mc && w[1]) men = 1;

            if (w[9]) mpwr = 0; else if (w[8]) mpwr = 1;

            if (disc) begin mph = 0; mcnt = 0; end
            else if (go_rst) begin mph = 1; mcnt = 0; end
            else if (go_rsm) begin mph = 2; mcnt = 0; end
            else if (mph == 3) begin
                if (mcnt == EOPC - 1) begin mph = 4; mcnt = 0; end else mcnt++;
            end else if (mph != 0 && tick) begin
                if (mph == 1 && mcnt == RMS - 1) begin mph = 0; mcnt = 0; end
                else if (mph == 2 && mcnt == SMS - 1) begin mph = 3; mcnt = 0; end
                else if (mph == 4 && mcnt == YMS - 1) begin mph = 0; mcnt = 0; end
                else mcnt++;
            end
            mc = lc; mls = lls; moc = loc;
        end
    end

    function automatic logic [31:0] model_rd();
        logic [31:0] r = '0;
        r[0] = mc; r[1] = men; r[2] = msus; r[3] = moc;
        r[4] = (mph == 1); r[5] = (mph >= 2); r[8] = mpwr; r[9] = mls && mc;
        r[16] = mcsc; r[17] = mpesc; r[18] = mpssc; r[19] = mocic; r[20] = mprsc;
        return r;
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp,
                       input logic [31:0] mask, input string tag);
        n_tests++;
        if ((act & mask) !== (exp & mask)) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (mask %h) at %0t",
                     tag, act & mask, exp & mask, mask, $time);
        end
    endtask

    // per-clock comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                cmp(rd0, model_rd(), 32'h0001_0001, "R3 model");
                cmp(rd0, model_rd(), 32'h0002_0002, "R7 model");
                cmp(rd0, model_rd(), 32'h0004_0024, "R6 model");
                cmp(rd0, model_rd(), 32'h0010_0010, "R5 model");
                cmp(rd0, model_rd(), 32'h0008_0008, "R9 model");
                cmp(rd0, model_rd(), 32'h0000_0300, "R10 model");
                cmp(rd0, model_rd(), 32'hFFE0_FCC0, "R1 model");
            end
        end
    end

    // 1 ms tick model: one pulse every TPER clocks
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            tick = (tc % TPER == 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TPER) @(negedge clk);
    endtask

    task automatic exp0(input logic [31:0] mask, input logic [31:0] val, input string tag);
        cmp(rd0, val, mask, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp0(32'hFFFF_FFFF, 32'h0, "R1 reset value");
        cmp(rd1, 32'h0001_0000, 32'h0001_0000, "R11 non-removable initial");

        wr(32'h0);
        cmp(rd1, 32'h0001_0000, 32'h0001_0000, "R2 write 0 keeps");
        wr(32'h0001_0000);
        cmp(rd1, 32'h0, 32'h0001_0000, "R2 write 1 clears");

        wr(32'h10);
        exp0(32'h0001_0012, 32'h0001_0000, "R4 reset refused");
        wr(32'h0001_0000);
        wr(32'h2);
        exp0(32'h0001_0002, 32'h0001_0000, "R4 enable refused");
        wr(32'h0001_0000);
        wr(32'h4);
        exp0(32'h0001_0004, 32'h0001_0000, "R4 suspend refused");
        wr(32'h0001_0000);

        @(negedge clk); lc = 1'b1; lls = 1'b1;
        @(negedge clk);
        exp0(32'h0001_0201, 32'h0001_0201, "R3 connect");
        cmp(rd1, 32'h0, 32'h0001_0000, "R11 connect ignored");
        wr(32'h0001_0000);

        wr(32'h100);
        exp0(32'h100, 32'h100, "R10 power on");
        wr(32'h200);
        exp0(32'h100, 32'h0, "R10 power off");

        wr(32'h10);
        exp0(32'h12, 32'h10, "R5 reset running");
        wait_ticks(RMS - 2);
        exp0(32'h0010_0010, 32'h10, "R5 reset not early");
        wait_ticks(2);
        exp0(32'h0010_0012, 32'h0010_0002, "R5 reset end");
        wr(32'h0010_0000);

        wr(32'h4);
        exp0(32'h4, 32'h4, "R6 suspend");
        wr(32'h8);
        exp0(32'h24, 32'h24, "R6 resume running");
        wait_ticks(SMS);
        exp0(32'h0004_0004, 32'h4, "R6 suspend held");
        wait_ticks(YMS + 3);
        exp0(32'h0004_0024, 32'h0004_0000, "R6 resume end");

        wr(32'h4);
        wr(32'h10);
        wait_ticks(RMS + 1);
        exp0(32'h0014_0006, 32'h0010_0002, "R5 resume-done killed by reset end");
        wr(32'h0010_0000);

        wr(32'h1);
        exp0(32'h0002_0002, 32'h0, "R7 sw disable no change");
        wr(32'h2);
        exp0(32'h0002_0002, 32'h2, "R7 sw enable no change");
        @(negedge clk); lerr = 1'b1;
        @(negedge clk); lerr = 1'b0;
        exp0(32'h0002_0002, 32'h0002_0000, "R7 hw disable");
        wr(32'h0002_0000);

        @(negedge clk); loc = 1'b1;
        @(negedge clk);
        exp0(32'h0008_0008, 32'h0008_0008, "R9 overcurrent change");
        wr(32'h0008_0000);
        @(negedge clk); loc = 1'b0; wr_en = 1'b1; wr_data = 32'h0008_0000;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        exp0(32'h0008_0008, 32'h0008_0000, "R2 set beats clear");
        wr(32'h0008_0000);

        wr(32'h2);
        wr(32'h4);
        wr(32'h8);
        wait_ticks(5);
        @(negedge clk); lc = 1'b0;
        @(negedge clk);
        exp0(32'h0007_0227, 32'h0001_0000, "R8 disconnect mid-resume");
        wait_ticks(SMS + YMS + 4);
        exp0(32'h0014_0000, 32'h0, "R8 no late completion");

        @(negedge clk); lc = 1'b1;
        @(negedge clk);
        cmp(rd1, 32'h0, 32'h0001_0000, "R11 reconnect ignored");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule